// File: doc/BRIEF.md
# Adapter Configuration Loader

After a start pulse, this block loads an adapter's power-up configuration from a serial EEPROM. It first asks for the adapter's early-enable step and waits until that step is acknowledged. It then sends eight single-byte read requests to an EEPROM reader, one at a time, and turns the returned bytes into configuration registers:

- a ring-speed flag, which also drives a speed-select pin;
- the on-board RAM size in kilobytes;
- a 48-bit station address.

The EEPROM wire protocol is handled by the reader and is outside this block.

The reader answers each request by pulsing either done or fail. A fail response is treated as if the byte 0xFF had been read, and loading continues. When the eighth response arrives, a loaded flag rises. The flag stays set until the next start pulse. The three EEPROM locations are parameters.

The controller is a five-state machine:

- `ST_IDLE`: waits for start after reset.
- `ST_ENABLE`: holds the enable request until it is acknowledged.
- `ST_ISSUE`: pulses a read request for one cycle.
- `ST_WAIT`: holds the address until the reader responds.
- `ST_DONE`: the loaded state.

Transitions:

- `ST_IDLE` goes to `ST_ENABLE` on start.
- `ST_ENABLE` goes to `ST_ISSUE` on the enable acknowledge.
- `ST_ISSUE` always goes to `ST_WAIT`.
- `ST_WAIT` goes to `ST_ISSUE` on a response, or to `ST_DONE` on the eighth response.
- `ST_DONE` goes to `ST_ENABLE` on start.

Top module: `cfg_loader`

## Requirements
- R1: After reset, `loaded`, `en_req`, `rd_req`, `slow_speed`, `speed_sel`, `ram_kb` and `station_addr` are all zero.
- R2: The cycle after a start pulse, `en_req` is 1. It stays 1 until `en_done` is seen, and no `rd_req` is issued while it is 1.
- R3: Reads are issued in this address order: `SPEED_LOC`, then `RAM_LOC`, then `MAC_BASE`+0 through `MAC_BASE`+5. Each `rd_req` is a one-cycle pulse. `rd_addr` holds steady until `rd_done` or `rd_fail`.
- R4: A nonzero speed byte sets `slow_speed` (4 Mb/s) and a zero byte clears it (16 Mb/s). `speed_sel` is 1 exactly when `slow_speed` is 1.
- R5: `ram_kb` equals the RAM byte multiplied by 128, as a 16-bit value.
- R6: The byte read from `MAC_BASE`+k lands in `station_addr[47-8k -: 8]`, so offset 0 is the most significant byte.
- R7: A read that ends with `rd_fail` is used as the byte 0xFF, whatever `rd_data` holds, and the next read follows.
- R8: `loaded` rises on the same clock edge that captures the eighth response. It stays 1 while no start arrives. A start pulse clears it on the next edge and begins a new load.
- R9: A start pulse while a load is in progress is ignored. The read sequence and its results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that starts a load |
| en_done | input | 1 | Acknowledge that the early-enable step has completed |
| en_req | output | 1 | Request for the early-enable step |
| rd_req | output | 1 | One-cycle pulse requesting one byte from the EEPROM reader |
| rd_addr | output | AW (8) | EEPROM location of the current read |
| rd_data | input | 8 | Byte returned with `rd_done` |
| rd_done | input | 1 | Read completed with valid data |
| rd_fail | input | 1 | Read failed |
| slow_speed | output | 1 | 1 = 4 Mb/s ring, 0 = 16 Mb/s |
| speed_sel | output | 1 | Speed-select pin, 1 for 4 Mb/s |
| ram_kb | output | 16 | On-board RAM size in kilobytes |
| station_addr | output | 48 | Station address, offset-0 byte in the top bits |
| loaded | output | 1 | All eight reads finished |

## Verification
The assertions rely on two rules about the inputs:

- `rd_done` and `rd_fail` only arrive while a read is outstanding, and never in the same cycle as the request itself.
- `en_done` only arrives while `en_req` is high.

The bench's responder keeps to both rules. It waits until it has seen `rd_req` or `en_req` at a falling edge, then answers after at least one further cycle. Each response is a single-cycle done or fail pulse, never both at once. Random byte values, random fail injection and start pulses placed in the middle of a load then exercise the substitution rule and the busy-state behaviour within those rules.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENABLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } ld_state_t;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned HDR_READS  = 2;   // speed byte, RAM byte
    localparam logic [7:0]  FAIL_BYTE  = 8'hFF;

endpackage

// File: rtl/cfg_loader_seq.sv
module cfg_loader_seq
    import cfg_loader_pkg::*;
#(
    parameter int unsigned AW        = 8,
    parameter int unsigned N_READS   = 8,
    parameter logic [AW-1:0] SPEED_LOC = 8'h02,
    parameter logic [AW-1:0] RAM_LOC   = 8'h03,
    parameter logic [AW-1:0] MAC_BASE  = 8'h10,
    localparam int unsigned IDX_W    = $clog2(N_READS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             en_done,
    input  logic             rd_done,
    input  logic             rd_fail,
    output logic             en_req,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    output logic             loaded,
    output logic             cap_en,
    output logic [IDX_W-1:0] cap_idx
);

    ld_state_t        state, state_nx;
    logic [IDX_W-1:0] idx;
    logic             resp;
    logic             last;

    assign resp = rd_done | rd_fail;
    assign last = (idx == IDX_W'(N_READS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)   state_nx = ST_ENABLE;
            ST_ENABLE: if (en_done) state_nx = ST_ISSUE;
            ST_ISSUE:               state_nx = ST_WAIT;
            ST_WAIT:   if (resp)    state_nx = last ? ST_DONE : ST_ISSUE;
            ST_DONE:   if (start)   state_nx = ST_ENABLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // read index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (state == ST_ENABLE) begin
            idx <= '0;
        end else if (state == ST_WAIT && resp && !last) begin
            idx <= idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        en_req  = (state == ST_ENABLE);
        rd_req  = (state == ST_ISSUE);
        loaded  = (state == ST_DONE);
        cap_en  = (state == ST_WAIT) && resp;
        cap_idx = idx;
        if (idx == '0) begin
            rd_addr = SPEED_LOC;
        end else if (idx == IDX_W'(1)) begin
            rd_addr = RAM_LOC;
        end else begin
            rd_addr = MAC_BASE + AW'(idx - IDX_W'(HDR_READS));
        end
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !resp) |=> $stable(rd_addr)); // R3
    AST_NO_READ_IN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        en_req |-> !rd_req); // R2
    AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && !start) |=> loaded); // R8
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && start) |=> (!loaded && en_req)); // R8
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && start && !resp) |=> (state == ST_WAIT)); // R9

endmodule

// File: rtl/cfg_loader_regs.sv
module cfg_loader_regs
    import cfg_loader_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned RAM_W      = 16,
    parameter int unsigned RAM_SHIFT  = 7,
    parameter int unsigned IDX_W      = 3,
    localparam int unsigned STA_W     = 8 * ADDR_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic             cap_fail,
    input  logic [7:0]       cap_byte,
    output logic             slow_speed,
    output logic [RAM_W-1:0] ram_kb,
    output logic [STA_W-1:0] station_addr
);

    logic [7:0] byte_eff;
    logic [7:0] sta_q [ADDR_BYTES];

    assign byte_eff = cap_fail ? FAIL_BYTE : cap_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow_speed <= 1'b0;
            ram_kb     <= '0;
            for (int k = 0; k < ADDR_BYTES; k++) sta_q[k] <= '0;
        end else if (cap_en) begin
            if (cap_idx == '0) slow_speed <= (byte_eff != 8'h00);
            if (cap_idx == IDX_W'(1)) ram_kb <= RAM_W'(byte_eff) << RAM_SHIFT;
            for (int k = 0; k < ADDR_BYTES; k++) begin
                if (cap_idx == IDX_W'(k + HDR_READS)) sta_q[k] <= byte_eff;
            end
        end
    end

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sta
        assign station_addr[STA_W-1-8*g -: 8] = sta_q[g];
    end

    AST_FAIL_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && cap_fail && cap_idx == '0) |=> slow_speed); // R7
    AST_ZERO_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !cap_fail && cap_idx == '0 && cap_byte == 8'h00) |=> !slow_speed); // R4

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned AW         = 8,
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned RAM_W      = 16,
    parameter logic [AW-1:0] SPEED_LOC = 8'h02,
    parameter logic [AW-1:0] RAM_LOC   = 8'h03,
    parameter logic [AW-1:0] MAC_BASE  = 8'h10,
    localparam int unsigned N_READS   = HDR_READS + ADDR_BYTES,
    localparam int unsigned IDX_W     = $clog2(N_READS),
    localparam int unsigned STA_W     = 8 * ADDR_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             en_done,
    output logic             en_req,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    input  logic [7:0]       rd_data,
    input  logic             rd_done,
    input  logic             rd_fail,
    output logic             slow_speed,
    output logic             speed_sel,
    output logic [RAM_W-1:0] ram_kb,
    output logic [STA_W-1:0] station_addr,
    output logic             loaded
);

    logic             cap_en;
    logic [IDX_W-1:0] cap_idx;

    cfg_loader_seq #(
        .AW(AW), .N_READS(N_READS),
        .SPEED_LOC(SPEED_LOC), .RAM_LOC(RAM_LOC), .MAC_BASE(MAC_BASE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .en_done(en_done),
        .rd_done(rd_done), .rd_fail(rd_fail), .en_req(en_req),
        .rd_req(rd_req), .rd_addr(rd_addr), .loaded(loaded),
        .cap_en(cap_en), .cap_idx(cap_idx)
    );

    cfg_loader_regs #(
        .ADDR_BYTES(ADDR_BYTES), .RAM_W(RAM_W), .RAM_SHIFT(7), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
        .cap_fail(rd_fail), .cap_byte(rd_data), .slow_speed(slow_speed),
        .ram_kb(ram_kb), .station_addr(station_addr)
    );

    assign speed_sel = slow_speed;

endmodule

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;

    localparam logic [7:0] P_SPEED = 8'h21;
    localparam logic [7:0] P_RAM   = 8'h22;
    localparam logic [7:0] P_MAC   = 8'h40;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst_n, start, en_done, rd_done, rd_fail;
    logic [7:0]  rd_data;
    logic        en_req, rd_req, slow_speed, speed_sel, loaded;
    logic [7:0]  rd_addr;
    logic [15:0] ram_kb;
    logic [47:0] station_addr;

    cfg_loader #(.SPEED_LOC(P_SPEED), .RAM_LOC(P_RAM), .MAC_BASE(P_MAC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .en_done(en_done),
        .en_req(en_req), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_done(rd_done), .rd_fail(rd_fail), .slow_speed(slow_speed),
        .speed_sel(speed_sel), .ram_kb(ram_kb), .station_addr(station_addr),
        .loaded(loaded)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;
    logic [7:0] rb [8];
    bit         rf [8];
    int         inj;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] eff(input int i);
        return rf[i] ? 8'hFF : rb[i];
    endfunction

    function automatic logic [7:0] exp_addr(input int i);
        if (i == 0) return P_SPEED;
        if (i == 1) return P_RAM;
        return P_MAC + 8'(i - 2);
    endfunction

    task automatic do_load();
        int d;
        int guard;
        logic [7:0] a;
        logic [47:0] exp_sta;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(en_req == 1'b1, "R2 en_req after start", 64'(en_req), 64'd1);
        chk(loaded == 1'b0, "R8 start clears loaded", 64'(loaded), 64'd0);
        d = $urandom % 4;
        for (int k = 0; k < d; k++) begin
            @(negedge clk);
            chk(en_req && !rd_req, "R2 hold enable, no read", 64'({en_req, rd_req}), 64'd2);
        end
        en_done = 1'b1;
        @(negedge clk);
        en_done = 1'b0;
        for (int i = 0; i < 8; i++) begin
            guard = 0;
            while (!rd_req && guard < 10) begin
                @(negedge clk);
                guard++;
            end
            chk(rd_req == 1'b1, "R3 read request", 64'(rd_req), 64'd1);
            chk(rd_addr == exp_addr(i), "R3 read address order", 64'(rd_addr), 64'(exp_addr(i)));
            a = rd_addr;
            d = 1 + ($urandom % 3);
            for (int k = 0; k < d; k++) begin
                start = (i == inj) && (k == 0);
                @(negedge clk);
                chk(!rd_req, "R3 request is one cycle", 64'(rd_req), 64'd0);
            end
            start = 1'b0;
            chk(rd_addr == a, "R3 address held", 64'(rd_addr), 64'(a));
            rd_done = !rf[i];
            rd_fail = rf[i];
            rd_data = rf[i] ? 8'($urandom) : rb[i];
            @(negedge clk);
            rd_done = 1'b0;
            rd_fail = 1'b0;
            rd_data = 8'h00;
            if (i < 7) chk(!loaded, "R8 not loaded mid-sequence", 64'(loaded), 64'd0);
        end
        exp_sta = {eff(2), eff(3), eff(4), eff(5), eff(6), eff(7)};
        chk(loaded == 1'b1, "R8 loaded after eighth read", 64'(loaded), 64'd1);
        chk(slow_speed == (eff(0) != 8'h00), "R4 R7 speed flag", 64'(slow_speed), 64'(eff(0) != 8'h00));
        chk(speed_sel == (eff(0) != 8'h00), "R4 speed pin", 64'(speed_sel), 64'(eff(0) != 8'h00));
        chk(ram_kb == 16'(eff(1)) * 16'd128, "R5 R7 ram size", 64'(ram_kb), 64'(16'(eff(1)) * 16'd128));
        chk(station_addr == exp_sta, "R6 R7 station address", 64'(station_addr), 64'(exp_sta));
        repeat (3) @(negedge clk);
        chk(loaded == 1'b1, "R8 loaded stays set", 64'(loaded), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; en_done = 1'b0;
        rd_done = 1'b0; rd_fail = 1'b0; rd_data = 8'h00;
        repeat (3) @(negedge clk);
        chk({loaded, en_req, rd_req, slow_speed, speed_sel} == 5'b0, "R1 reset flags",
            64'({loaded, en_req, rd_req, slow_speed, speed_sel}), 64'd0);
        chk(ram_kb == 16'd0 && station_addr == 48'd0, "R1 reset registers",
            64'(station_addr), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!en_req && !rd_req, "R1 idle without start", 64'({en_req, rd_req}), 64'd0);

        // directed: zero speed byte, no fails, known address
        for (int i = 0; i < 8; i++) begin rb[i] = 8'(i * 17); rf[i] = 0; end
        rb[0] = 8'h00; rb[1] = 8'h04;
        inj = -1;
        do_load();
        // directed: every read fails -> all 0xFF
        for (int i = 0; i < 8; i++) rf[i] = 1;
        do_load();
        // directed: start injected mid-load, nonzero speed byte
        for (int i = 0; i < 8; i++) begin rb[i] = 8'hA0 + 8'(i); rf[i] = 0; end
        inj = 4;
        do_load();
        // random
        for (int n = 0; n < 20; n++) begin
            for (int i = 0; i < 8; i++) begin
                rb[i] = 8'($urandom);
                rf[i] = (($urandom % 5) == 0);
            end
            if (($urandom % 3) == 0) rb[0] = 8'h00;
            inj = (($urandom % 2) == 0) ? int'($urandom % 8) : -1;
            do_load();
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule